// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor

This block drives the active-low reset of a host processor from the status of a group of supply rails. It comes out of reset holding the processor in reset. The processor is released only after every rail has been in regulation and free of faults for a fixed number of millisecond ticks. If any rail later shows a qualifying fault, the block asserts reset again on the next clock.

Each rail reports six status bits: overvoltage, undervoltage, overtemperature, short circuit, overcurrent timeout and orderly shutdown. Each rail also has a mode bit that sets how it responds to overvoltage and undervoltage. In the tripping mode these faults assert reset. In the flag-only mode they only set a readable flag. The overvoltage and undervoltage flags are latched per rail and stay set until the host clears them.

Top module: `rail_reset_supervisor`

## Requirements
- R1: After synchronous reset, `rst_n_out` is 0 and all `ov_flag` and `uv_flag` bits are 0.
- R2: While `rst_n_out` is 0 and no rail trips, `rst_n_out` becomes 1 on the clock after the HOLD_MS-th `ms_tick` counted while every rail is good. A rail is good when all six of its status bits are 0. Ticks that arrive while some rail is not good do not count.
- R3: If any rail stops being good during the hold count, the count restarts from zero.
- R4: `ot_in`, `sc_in` or `oct_in` high on any rail drives `rst_n_out` to 0 on the next clock edge, whatever the mode bit is.
- R5: `shdn_in` high on any rail drives `rst_n_out` to 0 on the next clock edge.
- R6: With `flag_only` bit i at 0, `ov_in` or `uv_in` bit i high drives `rst_n_out` to 0 on the next clock edge.
- R7: With `flag_only` bit i at 1, `ov_in` or `uv_in` bit i high leaves `rst_n_out` at 1. It still sets `ov_flag` or `uv_flag` bit i on the next clock edge.
- R8: `ov_flag` and `uv_flag` bits stay set after their inputs fall, until a `flag_clr` pulse. If the fault is still present during the clear, the flag stays set.
- R9: While `rst_n_out` is 0, a rail in flag-only mode with `ov_in` or `uv_in` high holds off release for as long as it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ov_in | input | N_RAILS | Overvoltage per rail (bit i = rail i) |
| uv_in | input | N_RAILS | Undervoltage per rail |
| ot_in | input | N_RAILS | Overtemperature per rail |
| sc_in | input | N_RAILS | Short circuit per rail |
| oct_in | input | N_RAILS | Overcurrent lasting past its limit, per rail |
| shdn_in | input | N_RAILS | Orderly shutdown in progress, per rail |
| flag_only | input | N_RAILS | 1: OV/UV only sets a flag; 0: OV/UV trips reset |
| flag_clr | input | 1 | Clears the latched OV/UV flags |
| rst_n_out | output | 1 | Active-low processor reset, registered |
| ov_flag | output | N_RAILS | Latched overvoltage flags |
| uv_flag | output | N_RAILS | Latched undervoltage flags |

## Verification
The hold count is tested in three ways. A clean run of ticks shows that exactly HOLD_MS ticks are needed. Idle cycles between ticks show that the count advances on ticks and not on clock cycles. A short not-good excursion in the middle of the count shows that the count restarts rather than pauses. Each fault source is then applied alone on a different rail against a released reset, so a missing term in the trip logic shows up for that source. The same overvoltage is applied in both mode settings, which separates tripping from flagging. The flag tests clear the flags both with the fault still present and after it has gone.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef struct packed {
    logic ov;
    logic uv;
    logic ot;
    logic sc;
    logic oct;
    logic shdn;
  } rail_status_t;
endpackage

// File: rtl/rail_monitor.sv
module rail_monitor
  import rsup_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  rail_status_t st,
  input  logic         flag_only,
  input  logic         flag_clr,
  output logic         good,
  output logic         trip,
  output logic         ov_flag,
  output logic         uv_flag
);
  logic ov_q, uv_q;

  always_comb begin
    good = !(st.ov | st.uv | st.ot | st.sc | st.oct | st.shdn);
    trip = st.ot | st.sc | st.oct | st.shdn | (!flag_only & (st.ov | st.uv));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      ov_q <= (ov_q & !flag_clr) | st.ov;
      uv_q <= (uv_q & !flag_clr) | st.uv;
    end
  end

  assign ov_flag = ov_q;
  assign uv_flag = uv_q;

  assert_ov_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !flag_clr) |=> ov_q);
  assert_uv_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (uv_q && !flag_clr) |=> uv_q);
endmodule

// File: rtl/reset_hold.sv
module reset_hold #(
  parameter int HOLD_MS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic all_good,
  input  logic any_trip,
  output logic rst_n
);
  localparam int CW = $clog2(HOLD_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

  logic [CW-1:0] cnt;
  logic          rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= 1'b0;
      cnt   <= '0;
    end else if (any_trip) begin
      rel_q <= 1'b0;
      cnt   <= '0;
    end else if (!rel_q) begin
      if (!all_good) begin
        cnt <= '0;
      end else if (ms_tick) begin
        if (cnt == LAST) begin
          rel_q <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rst_n = rel_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_release_good_R9: assert property (@(posedge clk) disable iff (rst)
    (!rel_q && !all_good) |=> !rel_q);
  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (!rel_q && !all_good) |=> cnt == '0);
endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
  import rsup_pkg::*;
#(
  parameter int N_RAILS = 4,
  parameter int HOLD_MS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ms_tick,
  input  logic [N_RAILS-1:0] ov_in,
  input  logic [N_RAILS-1:0] uv_in,
  input  logic [N_RAILS-1:0] ot_in,
  input  logic [N_RAILS-1:0] sc_in,
  input  logic [N_RAILS-1:0] oct_in,
  input  logic [N_RAILS-1:0] shdn_in,
  input  logic [N_RAILS-1:0] flag_only,
  input  logic               flag_clr,
  output logic               rst_n_out,
  output logic [N_RAILS-1:0] ov_flag,
  output logic [N_RAILS-1:0] uv_flag
);
  logic [N_RAILS-1:0] good_v, trip_v;
  logic all_good, any_trip;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    rail_status_t st;
    assign st = '{ov: ov_in[i], uv: uv_in[i], ot: ot_in[i], sc: sc_in[i],
                  oct: oct_in[i], shdn: shdn_in[i]};
    rail_monitor u_mon (
      .clk(clk), .rst(rst), .st(st), .flag_only(flag_only[i]),
      .flag_clr(flag_clr), .good(good_v[i]), .trip(trip_v[i]),
      .ov_flag(ov_flag[i]), .uv_flag(uv_flag[i])
    );
  end

  assign all_good = &good_v;
  assign any_trip = |trip_v;

  reset_hold #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .all_good(all_good),
    .any_trip(any_trip), .rst_n(rst_n_out)
  );

  assert_hard_fault_R4: assert property (@(posedge clk) disable iff (rst)
    |(ot_in | sc_in | oct_in) |=> !rst_n_out);
  assert_shutdown_R5: assert property (@(posedge clk) disable iff (rst)
    |shdn_in |=> !rst_n_out);
  assert_resp_a_R6: assert property (@(posedge clk) disable iff (rst)
    |((ov_in | uv_in) & ~flag_only) |=> !rst_n_out);
  assert_resp_b_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rst_n_out && !(|(ot_in | sc_in | oct_in | shdn_in | ((ov_in | uv_in) & ~flag_only))))
    |=> rst_n_out);
endmodule

// File: tb/rail_reset_supervisor_test.sv
module rail_reset_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int HOLD = 10;

  logic clk = 0, rst = 1, ms_tick = 0, flag_clr = 0;
  logic [N-1:0] ov_in = 0, uv_in = 0, ot_in = 0, sc_in = 0, oct_in = 0, shdn_in = 0, flag_only = 0;
  logic rst_n_out;
  logic [N-1:0] ov_flag, uv_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_reset_supervisor #(.N_RAILS(N), .HOLD_MS(HOLD)) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .ov_in(ov_in), .uv_in(uv_in),
    .ot_in(ot_in), .sc_in(sc_in), .oct_in(oct_in), .shdn_in(shdn_in),
    .flag_only(flag_only), .flag_clr(flag_clr), .rst_n_out(rst_n_out),
    .ov_flag(ov_flag), .uv_flag(uv_flag));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      ms_tick = 1; step(); ms_tick = 0; step();
    end
  endtask

  task automatic clear_all();
    ov_in = 0; uv_in = 0; ot_in = 0; sc_in = 0; oct_in = 0; shdn_in = 0;
  endtask

  task automatic bring_up();
    clear_all(); step(); tick(HOLD);
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0; step();
    chk("R1 rst_n", rst_n_out, 0);
    chk("R1 flags", {ov_flag, uv_flag}, 0);
  endtask

  task automatic t_release();
    tick(HOLD - 1);
    chk("R2 before last tick", rst_n_out, 0);
    repeat (5) step();
    chk("R2 idle cycles no count", rst_n_out, 0);
    tick(1);
    chk("R2 release", rst_n_out, 1);
  endtask

  task automatic trip_check(string req, int which, int rail);
    clear_all(); step();
    chk({req, " pre"}, rst_n_out, 1);
    case (which)
      0: ot_in[rail] = 1;
      1: sc_in[rail] = 1;
      2: oct_in[rail] = 1;
      3: shdn_in[rail] = 1;
      4: ov_in[rail] = 1;
      default: uv_in[rail] = 1;
    endcase
    step();
    chk(req, rst_n_out, 0);
    bring_up();
  endtask

  task automatic t_restart();
    trip_check("R4 ot", 0, 2);
    ot_in = 1; step(); clear_all(); step();
    tick(5);
    flag_only[1] = 1; uv_in[1] = 1; tick(1); uv_in[1] = 0;
    tick(HOLD - 1);
    chk("R3 restart", rst_n_out, 0);
    tick(1);
    chk("R3 release after full count", rst_n_out, 1);
    flag_only = 0;
  endtask

  task automatic t_resp_b();
    flag_clr = 1; step(); flag_clr = 0;
    flag_only[2] = 1;
    ov_in[2] = 1; uv_in[2] = 1;
    repeat (4) step();
    chk("R7 no reset", rst_n_out, 1);
    chk("R7 ov flag", ov_flag, 4'b0100);
    chk("R7 uv flag", uv_flag, 4'b0100);
    clear_all(); step();
  endtask

  task automatic t_flags();
    flag_only[0] = 1; ov_in[0] = 1; step(); ov_in[0] = 0; repeat (3) step();
    chk("R8 sticky", ov_flag[0], 1);
    ov_in[0] = 1; flag_clr = 1; step(); flag_clr = 0; ov_in[0] = 0; step();
    chk("R8 set wins over clear", ov_flag[0], 1);
    flag_clr = 1; step(); flag_clr = 0; step();
    chk("R8 cleared", {ov_flag, uv_flag}, 0);
    flag_only = 0;
  endtask

  task automatic t_hold_off();
    trip_check("R6 uv resp A", 5, 3);
    shdn_in[0] = 1; step(); clear_all();
    flag_only[2] = 1; ov_in[2] = 1;
    tick(HOLD + 5);
    chk("R9 hold off in flag mode", rst_n_out, 0);
    ov_in[2] = 0; step(); tick(HOLD);
    chk("R9 release after cleared", rst_n_out, 1);
    flag_only = 0;
  endtask

  initial begin
    t_reset();
    t_release();
    trip_check("R4 ot", 0, 0);
    trip_check("R4 sc", 1, 1);
    trip_check("R4 oct", 2, 3);
    trip_check("R5 shdn", 3, 2);
    trip_check("R6 ov resp A", 4, 1);
    chk("R6 ov flag set", ov_flag[1], 1);
    t_restart();
    t_resp_b();
    t_flags();
    t_hold_off();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule